// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind the bit-level front end of an I2C slave. The front end reports start conditions (including repeated starts) and stop conditions as one-cycle pulses. It also delivers each received byte on a valid/ready stream, with a flag that marks the first byte after a start. The recognizer checks that first byte against the device's own 7-bit address and against the general-call address. It then tells the front end whether to drive an acknowledge in the ACK slot, and it holds the transfer direction for the rest of the transfer.

The device address is assembled from two sources. A five-bit programmable field supplies address bits [7:3] of the address byte, and two strap pins supply bits [2:1]. Bit 0 of the address byte is the read/write flag, where 1 means read. A general call (byte 0x00) is acknowledged exactly like an own-address match. No separate indication of it is given.

While the device is selected, every later byte is passed unchanged to a registered output stream. The input stream applies back-pressure: `rx_ready` is low when the output register holds a byte the consumer has not taken. It is also low in any cycle that carries a start or stop pulse, so no byte is lost to an event. Bytes that arrive while the device is not selected are accepted and dropped. The enable input is high only in I2C slave mode. With it low, no address byte ever produces a match.

Top module: `i2c_adr_recog`

## Requirements
- R1: After reset, `sel`, `ack_req`, `rd_dir` and `dat_valid` are 0, and the block is unarmed.
- R2: An armed block that is enabled accepts a first-flagged byte whose bits [7:3] equal `own_addr` and whose bits [2:1] equal `addr_strap`. In the cycle after acceptance it raises `ack_req` for exactly one cycle and sets `sel`.
- R3: On a match, `rd_dir` takes bit 0 of the address byte (1 = read). It holds that value until the next start or stop pulse, and both of those pulses clear it.
- R4: A first-flagged byte equal to 0x00 is acknowledged exactly like an own-address match (`ack_req` pulse, `sel`=1, `rd_dir`=0). The bytes that follow are forwarded as ordinary data.
- R5: A first-flagged byte that matches neither address gives no `ack_req` and leaves `sel` at 0. All later bytes are dropped, even ones flagged first, until the next start pulse.
- R6: While `slave_en` is 0, no address byte causes `ack_req` or `sel`.
- R7: A start pulse clears `sel` in the next cycle and re-arms the block, so the next first-flagged byte is decoded as an address again.
- R8: A stop pulse clears `sel` and `ack_req` in the next cycle. Bytes that arrive afterwards are dropped until a start pulse arrives.
- R9: While selected, each accepted byte that is not flagged first appears on `dat_byte` with `dat_valid`=1 in the cycle after acceptance.
- R10: While `dat_valid`=1 and `dat_ready`=0, `dat_valid` stays 1, `dat_byte` stays unchanged and `rx_ready` is 0. `rx_ready` is also 0 in any cycle where `start_evt` or `stop_evt` is 1.
- R11: A first-flagged byte that arrives without a preceding start pulse (for example, directly after reset) is dropped and gives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_en | input | 1 | High only in I2C slave mode |
| own_addr | input | 5 | Programmable address bits, compared with byte bits [7:3] |
| addr_strap | input | 2 | Strap address bits, compared with byte bits [2:1] |
| start_evt | input | 1 | One-cycle pulse: start or repeated start seen |
| stop_evt | input | 1 | One-cycle pulse: stop seen |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Recognizer can take the byte |
| rx_byte | input | 8 | Received byte |
| rx_first | input | 1 | Byte is the first after a start |
| ack_req | output | 1 | One-cycle request to acknowledge the address byte |
| sel | output | 1 | Device addressed in the current transfer |
| rd_dir | output | 1 | Latched direction, 1 = read |
| dat_valid | output | 1 | Forwarded data byte available |
| dat_ready | input | 1 | Consumer takes the forwarded byte |
| dat_byte | output | 8 | Forwarded data byte |

## Verification
The hardest case to reach is a consumer that has stalled the output while the next input byte waits. When that consumer releases, the held byte must leave and the waiting byte must be captured at the same clock edge. The bench selects the device, holds `dat_ready` low, sends one data byte, then presents a second byte and checks that `rx_ready` stays low for several cycles. It then raises `dat_ready` and checks that the second byte takes the register with no gap. A second hard case is a repeated start that arrives while the device is selected in the read direction. The bench follows it with a mismatching address and checks that the session ends and that later data is dropped.

// File: rtl/i2c_adr_pkg.sv
package i2c_adr_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,  // unarmed, waiting for a start
    RS_ARMED = 2'd1,  // next first-flagged byte is an address
    RS_SEL   = 2'd2,  // addressed, forwarding data
    RS_MISS  = 2'd3   // address did not match, dropping
  } rec_state_e;
endpackage

// File: rtl/i2c_adr_match.sv
module i2c_adr_match #(
  parameter int REG_BITS   = 5,
  parameter int STRAP_BITS = 2,
  localparam int BYTE_W    = REG_BITS + STRAP_BITS + 1
) (
  input  logic [BYTE_W-1:0]     cand,
  input  logic [REG_BITS-1:0]   reg_part,
  input  logic [STRAP_BITS-1:0] strap_part,
  output logic                  own_hit,
  output logic                  gc_hit,
  output logic                  rw_bit
);
  localparam int REG_LSB = STRAP_BITS + 1;

  logic [REG_BITS-1:0]   cand_reg;
  logic [STRAP_BITS-1:0] cand_strap;

  assign cand_reg   = cand[BYTE_W-1:REG_LSB];
  assign cand_strap = cand[REG_LSB-1:1];

  always_comb begin
    own_hit = (cand_reg == reg_part) && (cand_strap == strap_part);
    gc_hit  = (cand == '0);
    rw_bit  = cand[0];
  end
endmodule

// File: rtl/i2c_adr_ctrl.sv
module i2c_adr_ctrl
  import i2c_adr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       enable,
  input  logic       addr_fire,
  input  logic       own_hit,
  input  logic       gc_hit,
  input  logic       rw_bit,
  output rec_state_e state,
  output logic       ack_req,
  output logic       rd_dir
);
  logic take_addr;
  logic hit;

  assign take_addr = addr_fire && (state == RS_ARMED);
  assign hit       = enable && (own_hit || gc_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RS_IDLE;
      ack_req <= 1'b0;
      rd_dir  <= 1'b0;
    end else begin
      ack_req <= 1'b0;
      if (stop_evt) begin
        state  <= RS_IDLE;
        rd_dir <= 1'b0;
      end else if (start_evt) begin
        state  <= RS_ARMED;
        rd_dir <= 1'b0;
      end else if (take_addr) begin
        if (hit) begin
          state   <= RS_SEL;
          ack_req <= 1'b1;
          rd_dir  <= rw_bit;
        end else begin
          state <= RS_MISS;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_adr_outreg.sv
module i2c_adr_outreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_adr_recog.sv
module i2c_adr_recog
  import i2c_adr_pkg::*;
#(
  parameter int REG_BITS   = 5,
  parameter int STRAP_BITS = 2,
  localparam int BYTE_W    = REG_BITS + STRAP_BITS + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slave_en,
  input  logic [REG_BITS-1:0]   own_addr,
  input  logic [STRAP_BITS-1:0] addr_strap,
  input  logic                  start_evt,
  input  logic                  stop_evt,
  input  logic                  rx_valid,
  output logic                  rx_ready,
  input  logic [BYTE_W-1:0]     rx_byte,
  input  logic                  rx_first,
  output logic                  ack_req,
  output logic                  sel,
  output logic                  rd_dir,
  output logic                  dat_valid,
  input  logic                  dat_ready,
  output logic [BYTE_W-1:0]     dat_byte
);
  rec_state_e state;
  logic       own_hit, gc_hit, rw_bit;
  logic       accept, addr_fire, data_load, stalled;

  assign stalled   = (state == RS_SEL) && dat_valid && !dat_ready;
  assign rx_ready  = !stalled && !start_evt && !stop_evt;
  assign accept    = rx_valid && rx_ready;
  assign addr_fire = accept && rx_first;
  assign data_load = accept && !rx_first && (state == RS_SEL);
  assign sel       = (state == RS_SEL);

  i2c_adr_match #(
    .REG_BITS   (REG_BITS),
    .STRAP_BITS (STRAP_BITS)
  ) u_match (
    .cand       (rx_byte),
    .reg_part   (own_addr),
    .strap_part (addr_strap),
    .own_hit    (own_hit),
    .gc_hit     (gc_hit),
    .rw_bit     (rw_bit)
  );

  i2c_adr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .enable    (slave_en),
    .addr_fire (addr_fire),
    .own_hit   (own_hit),
    .gc_hit    (gc_hit),
    .rw_bit    (rw_bit),
    .state     (state),
    .ack_req   (ack_req),
    .rd_dir    (rd_dir)
  );

  i2c_adr_outreg #(
    .WIDTH (BYTE_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (data_load),
    .din       (rx_byte),
    .out_ready (dat_ready),
    .out_valid (dat_valid),
    .dout      (dat_byte)
  );
endmodule

// File: rtl/i2c_adr_recog_chk.sv
module i2c_adr_recog_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_en,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_first,
  input logic              ack_req,
  input logic              sel,
  input logic              rd_dir,
  input logic              dat_valid,
  input logic              dat_ready,
  input logic [BYTE_W-1:0] dat_byte
);
  // R2
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(rx_valid && rx_ready && rx_first));
  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> !ack_req);
  // R6
  ack_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(slave_en));
  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> $stable(rd_dir));
  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sel && !ack_req));
  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sel);
  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !dat_ready) |=> (dat_valid && $stable(dat_byte)));
  // R10
  event_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |-> !rx_ready);
endmodule

bind i2c_adr_recog i2c_adr_recog_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slave_en  (slave_en),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_first  (rx_first),
  .ack_req   (ack_req),
  .sel       (sel),
  .rd_dir    (rd_dir),
  .dat_valid (dat_valid),
  .dat_ready (dat_ready),
  .dat_byte  (dat_byte)
);

// File: tb/test_i2c_adr_recog.sv
module test_i2c_adr_recog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slave_en = 1'b1;
  logic [4:0] own_addr = 5'b10110;
  logic [1:0] addr_strap = 2'b01;
  logic       start_evt = 1'b0, stop_evt = 1'b0;
  logic       rx_valid = 1'b0, rx_first = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       dat_ready = 1'b1;
  logic       rx_ready, ack_req, sel, rd_dir, dat_valid;
  logic [7:0] dat_byte;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] ADR_W = 8'hB2;  // 10110_01_0
  localparam logic [7:0] ADR_R = 8'hB3;

  always #4 clk = ~clk;

  i2c_adr_recog i_i2c_adr_recog (
    .clk, .rst_n, .slave_en, .own_addr, .addr_strap, .start_evt, .stop_evt,
    .rx_valid, .rx_ready, .rx_byte, .rx_first, .ack_req, .sel, .rd_dir,
    .dat_valid, .dat_ready, .dat_byte
  );

  task automatic chk(input logic cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_evt = 1'b1;
    @(negedge clk);
    start_evt = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
  endtask

  // presents a byte for one edge; returns at the next negedge
  task automatic send(input logic [7:0] b, input logic first);
    rx_byte  = b;
    rx_first = first;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_first = 1'b0;
  endtask

  task automatic t_reset();
    chk(!sel && !ack_req && !rd_dir && !dat_valid, "R1 reset outputs",
        {sel, ack_req, rd_dir, dat_valid}, 0);
  endtask

  task automatic t_unarmed();
    send(ADR_W, 1'b1);
    chk(!ack_req && !sel, "R11 no start, no ack", {ack_req, sel}, 0);
  endtask

  task automatic t_write_match();
    pulse_start();
    send(ADR_W, 1'b1);
    chk(ack_req && sel, "R2 own address ack", {ack_req, sel}, 3);
    chk(!rd_dir, "R3 write dir", rd_dir, 0);
    @(negedge clk);
    chk(!ack_req && sel, "R2 ack one cycle", {ack_req, sel}, 1);
    send(8'h5A, 1'b0);
    chk(dat_valid && dat_byte == 8'h5A, "R9 forward byte", dat_byte, 8'h5A);
    @(negedge clk);
    chk(!dat_valid, "R9 consumed", dat_valid, 0);
    pulse_stop();
    chk(!sel && !rd_dir, "R8 stop clears", {sel, rd_dir}, 0);
    send(8'h77, 1'b0);
    chk(!dat_valid, "R8 after stop dropped", dat_valid, 0);
  endtask

  task automatic t_read_restart();
    pulse_start();
    send(ADR_R, 1'b1);
    chk(ack_req && rd_dir, "R3 read dir", {ack_req, rd_dir}, 3);
    repeat (3) @(negedge clk);
    chk(rd_dir && sel, "R3 dir held", {rd_dir, sel}, 3);
    pulse_start();
    chk(!sel && !rd_dir, "R7 restart clears", {sel, rd_dir}, 0);
    send(8'hB6, 1'b1);  // strap bits differ
    chk(!ack_req && !sel, "R5 strap mismatch", {ack_req, sel}, 0);
    send(8'h11, 1'b0);
    send(ADR_W, 1'b1);
    chk(!ack_req && !sel && !dat_valid, "R5 drop until start",
        {ack_req, sel, dat_valid}, 0);
    pulse_start();
    send(8'h32, 1'b1);  // register bits differ
    chk(!ack_req && !sel, "R5 reg mismatch", {ack_req, sel}, 0);
    pulse_start();
    send(ADR_W, 1'b1);
    chk(ack_req && sel, "R7 re-armed match", {ack_req, sel}, 3);
    pulse_stop();
  endtask

  task automatic t_general_call();
    pulse_start();
    send(8'h00, 1'b1);
    chk(ack_req && sel && !rd_dir, "R4 general call ack",
        {ack_req, sel, rd_dir}, 6);
    send(8'h00, 1'b0);
    chk(dat_valid && dat_byte == 8'h00, "R4 following byte is data", dat_valid, 1);
    pulse_stop();
    pulse_start();
    send(8'h01, 1'b1);  // address 0 with read bit is not a general call
    chk(!ack_req && !sel, "R4 0x01 not acked", {ack_req, sel}, 0);
    pulse_stop();
  endtask

  task automatic t_disabled();
    slave_en = 1'b0;
    pulse_start();
    send(ADR_W, 1'b1);
    chk(!ack_req && !sel, "R6 disabled own", {ack_req, sel}, 0);
    pulse_start();
    send(8'h00, 1'b1);
    chk(!ack_req && !sel, "R6 disabled general call", {ack_req, sel}, 0);
    slave_en = 1'b1;
    pulse_stop();
  endtask

  task automatic t_backpressure();
    pulse_start();
    send(ADR_W, 1'b1);
    dat_ready = 1'b0;
    send(8'hA1, 1'b0);
    chk(dat_valid && dat_byte == 8'hA1, "R10 first held byte", dat_byte, 8'hA1);
    rx_byte  = 8'hC3;
    rx_valid = 1'b1;
    chk(!rx_ready, "R10 rx_ready low on stall", rx_ready, 0);
    repeat (3) @(negedge clk);
    chk(dat_valid && dat_byte == 8'hA1 && !rx_ready, "R10 hold during stall",
        dat_byte, 8'hA1);
    dat_ready = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(dat_valid && dat_byte == 8'hC3, "R10 second byte captured", dat_byte, 8'hC3);
    @(negedge clk);
    chk(!dat_valid, "R10 drained", dat_valid, 0);
    rx_valid  = 1'b1;
    rx_byte   = 8'h44;
    stop_evt  = 1'b1;
    #1;
    chk(!rx_ready, "R10 rx_ready low on stop", rx_ready, 0);
    @(negedge clk);
    stop_evt = 1'b0;
    rx_valid = 1'b0;
    @(negedge clk);
    chk(!dat_valid && !sel, "R8 byte with stop dropped", {dat_valid, sel}, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_write_match();
    t_read_restart();
    t_general_call();
    t_disabled();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule